// File: doc/BRIEF.md
# Whole-Register Vector Bit Shifter

This execution unit handles a single vector instruction: a right shift of an entire 128-bit register by zero to seven bits. Each cycle in which `in_valid` is high, it samples a 32-bit instruction word and two 128-bit operands, `src_a` and `src_b`. The unit checks the word against the expected primary/extended opcode pair. On a match, it shifts `src_a` toward its least significant end by a count taken from the low three bits of `src_b`. The result is registered and presented one clock later, together with the destination register index and a one-cycle write enable.

If the word does not match, no write happens. Instead the unit raises a one-cycle `illegal` pulse, and the result and destination outputs keep their previous values. No flags of any kind are produced. The surrounding pipeline owns register-file reads and writes, hazard handling and the byte-granular shifts that combine with this unit for longer shift distances.

Top module: `vbit_shift_unit`

## Requirements
- R1: A word is recognised only when `instr[31:26]` equals 4 and `instr[10:0]` equals 708 (0x2C4). With all register fields zero the word is 0x100002C4. A recognised word sampled with `in_valid` high produces `res_we` high on the next clock edge.
- R2: On a write, `res_dest` equals `instr[25:21]` of the sampled word. The source index fields in `instr[20:11]` have no effect on any output.
- R3: The shift count N is `src_b[2:0]`, the low bits of the least significant byte. `src_b[127:3]` has no effect on the result.
- R4: On a write, `res_data` equals `src_a` shifted right by N bits. Bits leaving the low end are discarded and zeros fill the high end.
- R5: When N is 0, `res_data` equals `src_a` exactly.
- R6: `res_we` is high for exactly one cycle per accepted recognised word. It is never high in a cycle that does not follow a sampled `in_valid`.
- R7: A word sampled with `in_valid` high that fails the R1 match raises `illegal` for one cycle and keeps `res_we` low. In that case `res_data` and `res_dest` keep their previous values.
- R8: Synchronous active-high `rst` drives `res_we`, `illegal`, `res_data` and `res_dest` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 32 | Instruction word, bit 31 is the big-endian bit 0 |
| src_a | input | 128 | Value to be shifted |
| src_b | input | 128 | Operand holding the shift count in bits 2:0 |
| res_data | output | 128 | Registered shift result |
| res_dest | output | 5 | Destination register index |
| res_we | output | 1 | One-cycle write enable |
| illegal | output | 1 | One-cycle unrecognised-word pulse |

## Verification
The bench walks the count through all eight values with an all-ones operand. A design that took the count from the wrong end of `src_b`, or that rotated instead of filling with zeros, would show stray ones at the top of the result. It also places one set bit at each byte boundary and shifts it across into the neighbouring byte. This exposes stage wiring that drops or duplicates carries between bytes. Upper `src_b` bits are randomised, and operands that differ only there must give identical results. Words that miss by one bit of either opcode must pulse `illegal` and leave the previous result and destination untouched. An implementation that updated on any valid, or that misplaced the big-endian field positions, fails these tests.

// File: rtl/vbit_shift_unit.sv
module vbit_shift_unit #(
  parameter int DATA_W  = 128,
  parameter int CNT_W   = 3,
  parameter int OPC_PRI = 4,
  parameter int OPC_EXT = 708
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic [DATA_W-1:0] res_data,
  output logic [4:0]        res_dest,
  output logic              res_we,
  output logic              illegal
);
  localparam int PRI_LSB  = 26;
  localparam int DEST_LSB = 21;
  localparam int EXT_W    = 11;

  logic [DATA_W-1:0] stage [CNT_W+1];
  logic [CNT_W-1:0]  cnt;
  logic              hit;

  assign cnt = src_b[CNT_W-1:0];
  assign hit = (instr[31:PRI_LSB] == 6'(OPC_PRI)) &&
               (instr[EXT_W-1:0]  == EXT_W'(OPC_EXT));

  assign stage[0] = src_a;
  for (genvar i = 0; i < CNT_W; i++) begin : g_stage
    assign stage[i+1] = cnt[i] ? (stage[i] >> (1 << i)) : stage[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_data <= '0;
      res_dest <= '0;
      res_we   <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      res_we  <= in_valid && hit;
      illegal <= in_valid && !hit;
      if (in_valid && hit) begin
        res_data <= stage[CNT_W];
        res_dest <= instr[DEST_LSB +: 5];
      end
    end
  end
endmodule

module vbit_shift_unit_chk #(
  parameter int DATA_W = 128,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [31:0]       instr,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic [DATA_W-1:0] res_data,
  input logic [4:0]        res_dest,
  input logic              res_we,
  input logic              illegal
);
  a_r6_we_needs_valid: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> !res_we);
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(res_we && illegal));
  a_r7_hold_data: assert property (@(posedge clk) disable iff (rst)
    illegal |-> ($stable(res_data) && $stable(res_dest)));
  a_r4_shift_result: assert property (@(posedge clk) disable iff (rst)
    res_we |-> (res_data == ($past(src_a) >> $past(src_b[CNT_W-1:0]))));
  a_r2_dest_index: assert property (@(posedge clk) disable iff (rst)
    res_we |-> (res_dest == $past(instr[25:21])));
endmodule

bind vbit_shift_unit vbit_shift_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_vbit_shift_unit.sv
module test_vbit_shift_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [31:0]  instr = '0;
  logic [127:0] src_a = '0;
  logic [127:0] src_b = '0;
  logic [127:0] res_data;
  logic [4:0]   res_dest;
  logic         res_we;
  logic         illegal;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  vbit_shift_unit i_vbit_shift_unit (.*);

  function automatic logic [31:0] mk(input logic [5:0] po, input logic [4:0] d,
                                     input logic [4:0] a, input logic [4:0] b,
                                     input logic [10:0] xo);
    return {po, d, a, b, xo};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [127:0] a,
                       input logic [127:0] b);
    @(negedge clk);
    in_valid = 1'b1; instr = w; src_a = a; src_b = b;
    @(negedge clk);
    in_valid = 1'b0; instr = '0; src_a = '0; src_b = '0;
  endtask

  task automatic shift_check(input string req, input logic [4:0] d,
                             input logic [127:0] a, input logic [127:0] b);
    logic [127:0] exp;
    exp = a >> (b[7:0] & 8'd7);
    issue(mk(6'd4, d, 5'd0, 5'd0, 11'd708), a, b);
    chk(res_we == 1'b1 && illegal == 1'b0, {req, " R1 we"}, 128'(res_we), 128'd1);
    chk(res_data == exp, req, res_data, exp);
    chk(res_dest == d, {req, " R2 dest"}, 128'(res_dest), 128'(d));
    @(negedge clk);
    chk(res_we == 1'b0, {req, " R6 single pulse"}, 128'(res_we), 128'd0);
  endtask

  task automatic t_reset;
    chk(res_we == 0 && illegal == 0, "R8 flags", {res_we, illegal}, 128'd0);
    chk(res_data == '0 && res_dest == '0, "R8 data", res_data, 128'd0);
  endtask

  task automatic t_all_counts;
    for (int n = 0; n < 8; n++) begin
      logic [127:0] b;
      b = {$urandom, $urandom, $urandom, $urandom};
      b[2:0] = 3'(n);
      shift_check(n == 0 ? "R5 count0" : "R4 ones", 5'(n + 3), '1, b);
    end
  endtask

  task automatic t_byte_edges;
    for (int k = 0; k < 16; k++) begin
      logic [127:0] b;
      b = {$urandom, $urandom, $urandom, $urandom};
      b[2:0] = 3'((k % 7) + 1);
      shift_check("R4 byte edge", 5'(k), 128'd1 << (8 * k), b);
    end
  endtask

  task automatic t_upper_b;
    logic [127:0] a, r0;
    a = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    issue(mk(6'd4, 5'd9, 5'd0, 5'd0, 11'd708), a, 128'h5);
    r0 = res_data;
    issue(mk(6'd4, 5'd9, 5'd0, 5'd0, 11'd708), a, {125'h1f0f_3c3c_aaaa_5555, 3'h5});
    chk(res_data == r0, "R3 upper bits ignored", res_data, r0);
    chk(r0 == (a >> 5), "R3 count from low byte", r0, a >> 5);
  endtask

  task automatic t_fields;
    logic [127:0] a;
    a = 128'hdead_beef_0000_1111_2222_3333_4444_5555;
    issue(mk(6'd4, 5'd31, 5'd17, 5'd22, 11'd708), a, 128'h2);
    chk(res_we && res_dest == 5'd31, "R2 dest with sources", 128'(res_dest), 128'd31);
    chk(res_data == (a >> 2), "R2 sources ignored", res_data, a >> 2);
  endtask

  task automatic t_illegal;
    logic [127:0] keep;
    keep = 128'hcafe >> 1;
    issue(mk(6'd4, 5'd7, 5'd0, 5'd0, 11'd708), 128'hcafe, 128'h1);
    chk(res_data == keep, "R1 baseline", res_data, keep);
    issue(mk(6'd4, 5'd12, 5'd1, 5'd2, 11'd709), '1, 128'h0);
    chk(illegal == 1 && res_we == 0, "R7 xo miss", {illegal, res_we}, 128'b10);
    chk(res_data == keep && res_dest == 5'd7, "R7 hold", res_data, keep);
    @(negedge clk);
    chk(illegal == 0, "R7 one cycle", 128'(illegal), 128'd0);
    issue(mk(6'd5, 5'd12, 5'd0, 5'd0, 11'd708), '1, 128'h0);
    chk(illegal == 1 && res_we == 0, "R1 primary miss", {illegal, res_we}, 128'b10);
    chk(res_data == keep && res_dest == 5'd7, "R7 hold2", res_data, keep);
  endtask

  task automatic t_idle;
    @(negedge clk);
    instr = mk(6'd4, 5'd1, 5'd0, 5'd0, 11'd708); src_a = '1;
    @(negedge clk);
    chk(res_we == 0 && illegal == 0, "R6 no valid", {res_we, illegal}, 128'd0);
    instr = '0; src_a = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_all_counts();
    t_byte_edges();
    t_upper_b();
    t_fields();
    t_illegal();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule